// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block turns a 32-bit linear page number into a physical page frame through a three-level table hierarchy with 64-bit entries. The four top-level entries are preloaded by the surrounding logic and are chosen by linear bits 31:30. The walker reads the directory entry and, for small pages, the table entry from memory. It checks every entry for presence and reserved bits, and it applies the privilege and execute-disable rules. It then writes back Accessed and Dirty updates and returns either a translation or a fault with an error code.

A lookup enters through a valid/ready request that carries the page number, write, read-modify-write, user and fetch flags, and three control bits. The control bits are the supervisor write-protect enable, the global-page enable and the execute-disable enable. Only one walk runs at a time. Memory traffic uses a request valid/ready port. A write completes when it is accepted. A read returns its data later with a single `mem_rvalid` pulse. The result is held on a valid/ready response port until it is taken.

Top module: `tlvl_walker`

## Requirements
- R1: The top entry comes from `top_cache` slice `[64*i +: 64]`, where i is linear bits 31:30, and it is never read from memory. The first read goes to `{top[PA_W-1:12], lin[29:21], 3'b000}`.
- R2: A walk ends with a fault in two cases. If an entry has bit 0 clear (not present), error bit 0 is 0. If a present entry has a reserved bit set, error bits 0 and 3 are both 1. The reserved bits are: top entry 2:1, 8:5 and 63:PA_W; directory and table entries 62:PA_W, plus 63 when execute-disable is off; a large-page directory entry also has 20:13.
- R3: If the directory entry has bit 7 set, it is the leaf and no table read happens. The frame is `{dir[PA_W-1:21], lin[20:12]}` and the mask is 0x1FFFFF.
- R4: Otherwise the table entry is read from `{dir[PA_W-1:12], lin[20:12], 3'b000}`. The frame is `table[PA_W-1:12]` and the mask is 0xFFF.
- R5: `rsp_acc` (bit 1 user-allowed, bit 0 writable) starts at 2'b11 and is ANDed with bits 2:1 of every directory and table entry visited.
- R6: The access is allowed according to a 5-bit index {wp, user, acc[1], acc[0], write}. A user access needs acc[1]=1, and a user write also needs acc[0]=1. A supervisor write with wp=1 needs acc[0]=1. A denied access faults with error bit 0 set.
- R7: When execute-disable is on, a fetch through a directory or table entry that has bit 63 set gives a protection fault. In that case error bit 4 is set, and bit 4 is set on any fault when execute-disable is on and the access is a fetch.
- R8: `rsp_global` equals leaf bit 8 when global pages are enabled, and is 0 otherwise.
- R9: For a small page whose directory entry has bit 5 (Accessed) clear, the directory entry is written back with bit 5 set, before any leaf write-back.
- R10: If the leaf has bit 5 clear, or a write finds bit 6 (Dirty) clear, the leaf is written back with bit 5 set and with bit 6 set on a write. No write happens otherwise.
- R11: A read-modify-write request behaves as a write for the Dirty update and for the privilege check.
- R12: A walk that faults writes nothing to memory.
- R13: `req_ready` is high only when the walker is idle. A memory request holds its address and data until accepted, and a response holds its value until `rsp_ready`. Error bits 1 and 2 carry the write and user flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Lookup request valid |
| req_ready | output | 1 | Walker idle and accepting |
| req_lin | input | 20 | Linear page number, bits 31:12 |
| req_write | input | 1 | Write access |
| req_rmw | input | 1 | Read-modify-write access |
| req_user | input | 1 | User-mode access |
| req_fetch | input | 1 | Instruction fetch |
| ctl_wp | input | 1 | Supervisor write-protect enable |
| ctl_glob_en | input | 1 | Global page enable |
| ctl_nx_en | input | 1 | Execute-disable enable |
| top_cache | input | 256 | Four preloaded top-level entries |
| mem_valid | output | 1 | Memory request valid |
| mem_ready | input | 1 | Memory request accepted |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | PA_W | Physical byte address of the entry |
| mem_wdata | output | 64 | Entry write data |
| mem_rvalid | input | 1 | Read data valid pulse |
| mem_rdata | input | 64 | Read data |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response taken |
| rsp_fault | output | 1 | Walk faulted |
| rsp_err | output | 5 | Error code: 0 protection, 1 write, 2 user, 3 reserved, 4 fetch |
| rsp_frame | output | PA_W-12 | Physical page frame |
| rsp_mask | output | 21 | Page-offset mask |
| rsp_global | output | 1 | Global translation |
| rsp_acc | output | 2 | Combined user/write permission |

## Verification
The embedded properties watch, on every cycle, the behaviours that hold regardless of the table contents. Memory requests and responses stay stable while stalled. No request is accepted while a walk or response is pending. A faulting walk has made no write. Every write-back carries the Accessed bit. A user translation that succeeds has user permission. The mask is one of the two legal values, and the global flag is clear when global pages are disabled. The values themselves can only be shown by the bench's table scenarios: frame and table-address formation at each size, the reserved masks, the privilege matrix, execute-disable, and the exact contents and number of write-backs.

// File: rtl/tlvl_pkg.sv
// Shared definitions for the three-level page walker.
// Assumes 64-bit entries with flag bits in the positions listed below.
package tlvl_pkg;

    typedef enum logic [3:0] {
        S_IDLE, S_TOP, S_DRD, S_DWT, S_DCHK, S_TRD, S_TWT, S_TCHK,
        S_PRIV, S_DWB, S_LWB, S_RSP
    } walk_st_t;

    localparam int ENT_W  = 64;
    localparam int N_LVL  = 3;
    localparam int LV_TOP = 0;
    localparam int LV_DIR = 1;
    localparam int LV_TBL = 2;

    // entry flag positions
    localparam int B_P  = 0;
    localparam int B_RW = 1;
    localparam int B_US = 2;
    localparam int B_A  = 5;
    localparam int B_D  = 6;
    localparam int B_PS = 7;
    localparam int B_G  = 8;
    localparam int B_NX = 63;

    // error code positions
    localparam int ERR_W  = 5;
    localparam int EB_P   = 0;
    localparam int EB_W   = 1;
    localparam int EB_U   = 2;
    localparam int EB_RSV = 3;
    localparam int EB_FET = 4;

    // Permission rule for index {wp, user, user_ok, writable, write}.
    function automatic logic priv_rule(input logic [4:0] idx);
        logic wp, usr, us_ok, rw_ok, wr;
        {wp, usr, us_ok, rw_ok, wr} = idx;
        if (usr)
            return us_ok && (rw_ok || !wr);
        return !(wr && wp && !rw_ok);
    endfunction

endpackage

// File: rtl/tlvl_entry_check.sv
// Checks one table entry for presence, reserved bits and execute-disable hits.
// Assumes LVL selects the reserved-bit layout of the top, directory or table level.
module tlvl_entry_check
    import tlvl_pkg::*;
#(
    parameter int PA_W = 52,
    parameter int LVL  = LV_DIR
) (
    input  logic [ENT_W-1:0] ent,
    input  logic             nx_en,
    input  logic             fetch,
    output logic             present,
    output logic             rsvd,
    output logic             nx_hit
);

    logic [ENT_W-1:0] rmask;

    // Build the reserved-bit mask for this level.
    always_comb begin
        rmask = '0;
        for (int b = PA_W; b < ENT_W - 1; b++)
            rmask[b] = 1'b1;
        rmask[B_NX] = (LVL == LV_TOP) || !nx_en;
        if (LVL == LV_TOP) begin
            rmask[2:1] = 2'b11;
            rmask[8:5] = 4'hF;
        end
        if (LVL == LV_DIR && ent[B_PS])
            rmask[20:13] = 8'hFF;
    end

    // Presence, reserved-bit and execute-disable outcomes.
    always_comb begin
        present = ent[B_P];
        rsvd    = ent[B_P] && (|(ent & rmask));
        nx_hit  = (LVL != LV_TOP) && nx_en && fetch && ent[B_NX] && ent[B_P];
    end

endmodule

// File: rtl/tlvl_priv_lut.sv
// Permission lookup: a 32-entry table indexed by {wp, user, user_ok, writable, write}.
// Assumes the index is already assembled from registered walk state.
module tlvl_priv_lut
    import tlvl_pkg::*;
(
    input  logic [4:0] idx,
    output logic       allow
);

    logic [31:0] lut;

    for (genvar i = 0; i < 32; i++) begin : g_lut
        assign lut[i] = priv_rule(5'(i));
    end

    // Select the verdict for the current access.
    assign allow = lut[idx];

endmodule

// File: rtl/tlvl_walker.sv
// Three-level page walker: cached top entry, directory read, optional table read,
// protection check, then Accessed/Dirty write-backs before the response.
// Assumes one walk at a time, writes complete on acceptance, and reads return
// their data with a single mem_rvalid pulse after acceptance.
module tlvl_walker
    import tlvl_pkg::*;
#(
    parameter int PA_W = 52
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic [31:12]         req_lin,
    input  logic                 req_write,
    input  logic                 req_rmw,
    input  logic                 req_user,
    input  logic                 req_fetch,
    input  logic                 ctl_wp,
    input  logic                 ctl_glob_en,
    input  logic                 ctl_nx_en,
    input  logic [4*64-1:0]      top_cache,
    output logic                 mem_valid,
    input  logic                 mem_ready,
    output logic                 mem_we,
    output logic [PA_W-1:0]      mem_addr,
    output logic [63:0]          mem_wdata,
    input  logic                 mem_rvalid,
    input  logic [63:0]          mem_rdata,
    output logic                 rsp_valid,
    input  logic                 rsp_ready,
    output logic                 rsp_fault,
    output logic [4:0]           rsp_err,
    output logic [PA_W-13:0]     rsp_frame,
    output logic [20:0]          rsp_mask,
    output logic                 rsp_global,
    output logic [1:0]           rsp_acc
);

    localparam int FRAME_W = PA_W - 12;
    localparam int MASK_W  = 21;
    localparam logic [MASK_W-1:0] MASK_BIG   = '1;
    localparam logic [MASK_W-1:0] MASK_SMALL = MASK_W'(12'hFFF);

    walk_st_t          st, nxt;
    logic [29:12]      lin_q;
    logic              wr_q, usr_q, fet_q, wp_q, ge_q, nx_q;
    logic [ENT_W-1:0]  ent_q [N_LVL];
    logic [1:0]        acc_q;

    logic [N_LVL-1:0]  pres, rsv, nxh;
    logic              allow, big, nx_viol, leaf_upd;
    logic [ENT_W-1:0]  leaf, leaf_new;
    logic [PA_W-1:0]   dir_addr, tbl_addr, leaf_addr;
    logic              fin, fin_flt, fin_p, fin_rsv;

    logic              rsp_fault_q, rsp_glob_q;
    logic [ERR_W-1:0]  rsp_err_q;
    logic [FRAME_W-1:0] rsp_frame_q;
    logic [MASK_W-1:0] rsp_mask_q;
    logic [1:0]        rsp_acc_q;

    // One entry checker per level, each with its own reserved layout.
    for (genvar l = 0; l < N_LVL; l++) begin : g_chk
        tlvl_entry_check #(.PA_W(PA_W), .LVL(l)) i_chk (
            .ent     (ent_q[l]),
            .nx_en   (nx_q),
            .fetch   (fet_q),
            .present (pres[l]),
            .rsvd    (rsv[l]),
            .nx_hit  (nxh[l])
        );
    end

    tlvl_priv_lut i_priv (
        .idx   ({wp_q, usr_q, acc_q, wr_q}),
        .allow (allow)
    );

    // Entry addresses, leaf selection and the leaf's updated value.
    always_comb begin
        big       = ent_q[LV_DIR][B_PS];
        dir_addr  = {ent_q[LV_TOP][PA_W-1:12], lin_q[29:21], 3'b000};
        tbl_addr  = {ent_q[LV_DIR][PA_W-1:12], lin_q[20:12], 3'b000};
        leaf      = big ? ent_q[LV_DIR] : ent_q[LV_TBL];
        leaf_addr = big ? dir_addr : tbl_addr;
        leaf_upd  = !leaf[B_A] || (wr_q && !leaf[B_D]);
        leaf_new  = leaf;
        leaf_new[B_A] = 1'b1;
        if (wr_q)
            leaf_new[B_D] = 1'b1;
        nx_viol   = nxh[LV_TOP] | nxh[LV_DIR] | (!big & nxh[LV_TBL]);
    end

    // Next state, memory port drive and walk termination.
    always_comb begin
        nxt       = st;
        fin       = 1'b0;
        fin_flt   = 1'b0;
        fin_p     = 1'b0;
        fin_rsv   = 1'b0;
        mem_valid = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = dir_addr;
        mem_wdata = ent_q[LV_DIR] | (64'd1 << B_A);
        case (st)
            S_IDLE: if (req_valid) nxt = S_TOP;
            S_TOP: begin
                if (!pres[LV_TOP]) begin
                    fin = 1'b1; fin_flt = 1'b1;
                end else if (rsv[LV_TOP]) begin
                    fin = 1'b1; fin_flt = 1'b1; fin_p = 1'b1; fin_rsv = 1'b1;
                end else begin
                    nxt = S_DRD;
                end
            end
            S_DRD: begin
                mem_valid = 1'b1;
                if (mem_ready) nxt = S_DWT;
            end
            S_DWT: if (mem_rvalid) nxt = S_DCHK;
            S_DCHK: begin
                if (!pres[LV_DIR]) begin
                    fin = 1'b1; fin_flt = 1'b1;
                end else if (rsv[LV_DIR]) begin
                    fin = 1'b1; fin_flt = 1'b1; fin_p = 1'b1; fin_rsv = 1'b1;
                end else begin
                    nxt = big ? S_PRIV : S_TRD;
                end
            end
            S_TRD: begin
                mem_valid = 1'b1;
                mem_addr  = tbl_addr;
                if (mem_ready) nxt = S_TWT;
            end
            S_TWT: if (mem_rvalid) nxt = S_TCHK;
            S_TCHK: begin
                if (!pres[LV_TBL]) begin
                    fin = 1'b1; fin_flt = 1'b1;
                end else if (rsv[LV_TBL]) begin
                    fin = 1'b1; fin_flt = 1'b1; fin_p = 1'b1; fin_rsv = 1'b1;
                end else begin
                    nxt = S_PRIV;
                end
            end
            S_PRIV: begin
                if (!allow || nx_viol) begin
                    fin = 1'b1; fin_flt = 1'b1; fin_p = 1'b1;
                end else if (!big && !ent_q[LV_DIR][B_A]) begin
                    nxt = S_DWB;
                end else if (leaf_upd) begin
                    nxt = S_LWB;
                end else begin
                    fin = 1'b1;
                end
            end
            S_DWB: begin
                mem_valid = 1'b1;
                mem_we    = 1'b1;
                if (mem_ready) begin
                    if (leaf_upd) nxt = S_LWB;
                    else          fin = 1'b1;
                end
            end
            S_LWB: begin
                mem_valid = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = leaf_addr;
                mem_wdata = leaf_new;
                if (mem_ready) fin = 1'b1;
            end
            S_RSP: if (rsp_ready) nxt = S_IDLE;
            default: nxt = S_IDLE;
        endcase
        if (fin) nxt = S_RSP;
    end

    // Walk state, captured request, fetched entries and the response registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st          <= S_IDLE;
            lin_q       <= '0;
            {wr_q, usr_q, fet_q, wp_q, ge_q, nx_q} <= '0;
            for (int l = 0; l < N_LVL; l++) ent_q[l] <= '0;
            acc_q       <= 2'b11;
            rsp_fault_q <= 1'b0;
            rsp_err_q   <= '0;
            rsp_frame_q <= '0;
            rsp_mask_q  <= '0;
            rsp_glob_q  <= 1'b0;
            rsp_acc_q   <= '0;
        end else begin
            st <= nxt;
            if (st == S_IDLE && req_valid) begin
                lin_q         <= req_lin[29:12];
                wr_q          <= req_write | req_rmw;
                usr_q         <= req_user;
                fet_q         <= req_fetch;
                wp_q          <= ctl_wp;
                ge_q          <= ctl_glob_en;
                nx_q          <= ctl_nx_en;
                ent_q[LV_TOP] <= top_cache[{req_lin[31:30], 6'd0} +: ENT_W];
                acc_q         <= 2'b11;
            end
            if (st == S_DWT && mem_rvalid) ent_q[LV_DIR] <= mem_rdata;
            if (st == S_TWT && mem_rvalid) ent_q[LV_TBL] <= mem_rdata;
            if (st == S_DCHK) acc_q <= acc_q & ent_q[LV_DIR][2:1];
            if (st == S_TCHK) acc_q <= acc_q & ent_q[LV_TBL][2:1];
            if (fin) begin
                rsp_fault_q <= fin_flt;
                rsp_err_q   <= fin_flt ? {fet_q & nx_q, fin_rsv, usr_q, wr_q, fin_p} : '0;
                rsp_frame_q <= fin_flt ? '0 :
                               big ? {ent_q[LV_DIR][PA_W-1:21], lin_q[20:12]}
                                   : ent_q[LV_TBL][PA_W-1:12];
                rsp_mask_q  <= fin_flt ? '0 : (big ? MASK_BIG : MASK_SMALL);
                rsp_glob_q  <= !fin_flt && ge_q && leaf[B_G];
                rsp_acc_q   <= fin_flt ? 2'b00 : acc_q;
            end
        end
    end

    assign req_ready  = (st == S_IDLE);
    assign rsp_valid  = (st == S_RSP);
    assign rsp_fault  = rsp_fault_q;
    assign rsp_err    = rsp_err_q;
    assign rsp_frame  = rsp_frame_q;
    assign rsp_mask   = rsp_mask_q;
    assign rsp_global = rsp_glob_q;
    assign rsp_acc    = rsp_acc_q;

    // Tracks whether the current walk has completed any memory write.
    logic wr_seen_q;
    always_ff @(posedge clk) begin
        if (!rst_n)
            wr_seen_q <= 1'b0;
        else if (req_valid && req_ready)
            wr_seen_q <= 1'b0;
        else if (mem_valid && mem_we && mem_ready)
            wr_seen_q <= 1'b1;
    end

    a_r13_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata))
        else $error("a_r13_mem_hold");

    a_r13_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_ready |=> rsp_valid && $stable({rsp_fault, rsp_err, rsp_frame, rsp_mask, rsp_global, rsp_acc}))
        else $error("a_r13_rsp_hold");

    a_r13_single_walk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !mem_valid && !rsp_valid)
        else $error("a_r13_single_walk");

    a_r12_no_write_on_fault: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_fault |-> !wr_seen_q)
        else $error("a_r12_no_write_on_fault");

    a_r10_wb_sets_a: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid && mem_we |-> mem_wdata[B_A])
        else $error("a_r10_wb_sets_a");

    a_r6_user_ok: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_fault && usr_q |-> rsp_acc[1])
        else $error("a_r6_user_ok");

    a_r8_global_gate: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !ge_q |-> !rsp_global)
        else $error("a_r8_global_gate");

    a_r3_mask_legal: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_fault |-> (rsp_mask == MASK_BIG) || (rsp_mask == MASK_SMALL))
        else $error("a_r3_mask_legal");

endmodule

// File: tb/test_tlvl_walker.sv
`timescale 1ns/1ps
module test_tlvl_walker;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         req_valid, req_ready, req_write, req_rmw, req_user, req_fetch;
    logic [31:12] req_lin;
    logic         ctl_wp, ctl_glob_en, ctl_nx_en;
    logic [255:0] top_cache;
    logic         mem_valid, mem_ready, mem_we, mem_rvalid;
    logic [51:0]  mem_addr;
    logic [63:0]  mem_wdata, mem_rdata;
    logic         rsp_valid, rsp_ready, rsp_fault, rsp_global;
    logic [4:0]   rsp_err;
    logic [39:0]  rsp_frame;
    logic [20:0]  rsp_mask;
    logic [1:0]   rsp_acc;

    int n_chk = 0, n_bad = 0, n_rd = 0, n_wr = 0;
    bit done = 0;
    logic [63:0] mem [logic [51:0]];

    typedef struct {
        string       tag;
        logic        fault;
        logic [4:0]  err;
        logic [39:0] frame;
        logic [20:0] mask;
        logic        glob;
        logic [1:0]  acc;
        int          reads;
        int          writes;
        logic        has_d;
        logic [51:0] daddr;
        logic [63:0] dval;
        logic        has_l;
        logic [51:0] laddr;
        logic [63:0] lval;
    } exp_t;
    exp_t sbq[$];

    tlvl_walker i_tlvl_walker (.*);

    initial forever #2.5 clk = ~clk;

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, expv);
        end
    endtask

    function automatic logic [63:0] rdm(input logic [51:0] a);
        return mem.exists(a) ? mem[a] : 64'd0;
    endfunction

    // Expected outcome computed from the requirement text.
    function automatic exp_t model(input logic [31:0] la, input logic w, input logic u,
                                   input logic f, input logic wp, input logic ge, input logic nx);
        exp_t e;
        logic [63:0] t, d, l, dm;
        logic [1:0] acc;
        logic big, ok;
        logic [4:0] base;
        e.tag = ""; e.fault = 0; e.err = 0; e.frame = 0; e.mask = 0; e.glob = 0; e.acc = 0;
        e.reads = 0; e.writes = 0; e.has_d = 0; e.daddr = 0; e.dval = 0;
        e.has_l = 0; e.laddr = 0; e.lval = 0;
        base = {f & nx, 1'b0, u, w, 1'b0};
        t = top_cache[la[31:30]*64 +: 64];
        if (!t[0]) begin e.fault = 1; e.err = base; return e; end
        if ((t & 64'hFFF0_0000_0000_01E6) != 0) begin e.fault = 1; e.err = base | 5'b01001; return e; end
        e.daddr = {t[51:12], la[29:21], 3'b000};
        d = rdm(e.daddr); e.reads = 1; e.has_d = 1; e.dval = d;
        if (!d[0]) begin e.fault = 1; e.err = base; return e; end
        dm = 64'h7FF0_0000_0000_0000 | (nx ? 64'd0 : 64'h8000_0000_0000_0000);
        if ((d & (dm | (d[7] ? 64'h1F_E000 : 64'd0))) != 0) begin e.fault = 1; e.err = base | 5'b01001; return e; end
        acc = d[2:1];
        big = d[7];
        l = d;
        if (!big) begin
            e.laddr = {d[51:12], la[20:12], 3'b000};
            l = rdm(e.laddr); e.reads = 2; e.has_l = 1; e.lval = l;
            if (!l[0]) begin e.fault = 1; e.err = base; return e; end
            if ((l & dm) != 0) begin e.fault = 1; e.err = base | 5'b01001; return e; end
            acc = acc & l[2:1];
        end
        ok = u ? (acc[1] && (acc[0] || !w)) : !(w && wp && !acc[0]);
        if (!ok || (nx && f && (d[63] || (!big && l[63])))) begin
            e.fault = 1; e.err = base | 5'b00001; return e;
        end
        if (!big && !d[5]) begin e.dval = d | 64'h20; e.writes++; end
        if (!l[5] || (w && !l[6])) begin
            e.writes++;
            if (big) e.dval = l | 64'h20 | (w ? 64'h40 : 64'h0);
            else     e.lval = l | 64'h20 | (w ? 64'h40 : 64'h0);
        end
        e.frame = big ? {d[51:21], la[20:12]} : l[51:12];
        e.mask  = big ? 21'h1FFFFF : 21'h000FFF;
        e.glob  = ge & l[8];
        e.acc   = acc;
        return e;
    endfunction

    // Memory responder: stalls acceptance every third cycle, returns read data one cycle later.
    initial begin
        int cyc = 0;
        bit pend = 0;
        logic [63:0] pdat = '0;
        mem_ready = 0; mem_rvalid = 0; mem_rdata = '0;
        forever begin
            @(negedge clk);
            cyc++;
            mem_rvalid = 0;
            if (pend) begin mem_rvalid = 1; mem_rdata = pdat; pend = 0; end
            mem_ready = (cyc % 3) != 0;
            if (rst_n && mem_valid && mem_ready) begin
                if (mem_we) begin mem[mem_addr] = mem_wdata; n_wr++; end
                else begin pdat = rdm(mem_addr); pend = 1; n_rd++; end
            end
        end
    end

    // Response monitor: pops the scoreboard on each accepted response.
    initial begin
        int cyc = 0;
        exp_t e;
        rsp_ready = 0;
        forever begin
            @(negedge clk);
            cyc++;
            rsp_ready = (cyc % 4) != 1;
            if (rst_n && rsp_valid && rsp_ready) begin
                if (sbq.size() == 0) begin
                    chk(0, "R13", "unexpected response", 64'(rsp_fault), 64'd0);
                end else begin
                    e = sbq.pop_front();
                    chk({rsp_fault, rsp_err, rsp_frame, rsp_mask, rsp_global, rsp_acc} ==
                        {e.fault, e.err, e.frame, e.mask, e.glob, e.acc}, e.tag,
                        "response {fault,err,frame}",
                        {rsp_fault, 13'd0, rsp_err, 5'd0, rsp_frame},
                        {e.fault, 13'd0, e.err, 5'd0, e.frame});
                end
            end
        end
    end

    task automatic walk(input string tag, input logic [31:0] la, input logic w, input logic rmw,
                        input logic u, input logic f, input logic wp, input logic ge, input logic nx);
        exp_t e;
        int r0, w0;
        e = model(la, w | rmw, u, f, wp, ge, nx);
        e.tag = tag;
        r0 = n_rd; w0 = n_wr;
        sbq.push_back(e);
        @(negedge clk);
        req_lin = la[31:12]; req_write = w; req_rmw = rmw; req_user = u; req_fetch = f;
        ctl_wp = wp; ctl_glob_en = ge; ctl_nx_en = nx; req_valid = 1;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 0;
        while (sbq.size() != 0) @(negedge clk);
        @(negedge clk);
        chk(n_rd - r0 == e.reads, tag, "read count", 64'(n_rd - r0), 64'(e.reads));
        chk(n_wr - w0 == e.writes, tag, "write count", 64'(n_wr - w0), 64'(e.writes));
        if (e.has_d) chk(rdm(e.daddr) == e.dval, tag, "directory entry", rdm(e.daddr), e.dval);
        if (e.has_l) chk(rdm(e.laddr) == e.lval, tag, "table entry", rdm(e.laddr), e.lval);
    endtask

    initial begin
        #500000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        rst_n = 0; req_valid = 0; req_lin = '0; req_write = 0; req_rmw = 0; req_user = 0;
        req_fetch = 0; ctl_wp = 0; ctl_glob_en = 0; ctl_nx_en = 0;
        top_cache = '0;
        top_cache[0*64 +: 64] = 64'h0000_0000_0001_0001;
        top_cache[3*64 +: 64] = 64'h0000_0000_0003_0001;
        repeat (4) @(negedge clk);
        // R13: reset state
        chk(req_ready == 1'b1, "R13", "req_ready after reset", 64'(req_ready), 64'd1);
        chk(rsp_valid == 1'b0, "R13", "rsp_valid after reset", 64'(rsp_valid), 64'd0);
        chk(mem_valid == 1'b0, "R13", "mem_valid after reset", 64'(mem_valid), 64'd0);
        rst_n = 1;
        repeat (2) @(negedge clk);

        // R4 R5: small page, nothing to update
        mem[52'h10010] = 64'h20027; mem[52'h20018] = 64'h0ABCD065;
        walk("R4_R5_small_read", 32'h0040_3000, 0, 0, 0, 0, 0, 0, 0);
        // R9 R10: both Accessed bits clear, write sets A and D
        mem[52'h10010] = 64'h20007; mem[52'h20018] = 64'h0ABCD007;
        walk("R9_R10_write_updates", 32'h0040_3000, 1, 0, 0, 0, 0, 0, 0);
        // R3 R8: large page with global bit, global enabled
        mem[52'h10028] = 64'h600187;
        walk("R3_R8_large_global", 32'h00A0_5000, 0, 0, 0, 0, 0, 1, 0);
        walk("R8_global_disabled", 32'h00A0_5000, 0, 0, 0, 0, 0, 0, 0);
        // R1: top entry chosen by bits 31:30
        mem[52'h30010] = 64'h40027; mem[52'h40018] = 64'h01234065;
        walk("R1_top_index3", 32'hC040_3000, 0, 0, 0, 0, 0, 0, 0);
        // R2: not-present top, directory; reserved table bit
        walk("R2_top_absent", 32'h4000_0000, 1, 0, 0, 0, 0, 0, 0);
        walk("R2_dir_absent", 32'h00E0_0000, 0, 0, 0, 0, 0, 0, 0);
        mem[52'h10010] = 64'h20027; mem[52'h20018] = 64'h0010_0000_0ABC_D065;
        walk("R2_tbl_reserved", 32'h0040_3000, 0, 0, 0, 0, 0, 0, 0);
        // R6 R12: user read of supervisor page faults without touching A bits
        mem[52'h10010] = 64'h20007; mem[52'h20018] = 64'h0ABCD003;
        walk("R6_R12_user_super", 32'h0040_3000, 0, 0, 1, 0, 0, 0, 0);
        // R6: user write to read-only page
        mem[52'h10010] = 64'h20027; mem[52'h20018] = 64'h0ABCD025;
        walk("R6_user_write_ro", 32'h0040_3000, 1, 0, 1, 0, 0, 0, 0);
        // R6: supervisor write to read-only, protection off then on
        walk("R6_super_write_wp0", 32'h0040_3000, 1, 0, 0, 0, 0, 0, 0);
        mem[52'h20018] = 64'h0ABCD025;
        walk("R6_super_write_wp1", 32'h0040_3000, 1, 0, 0, 0, 1, 0, 0);
        // R7: execute-disable
        mem[52'h20018] = 64'h8000_0000_0ABC_D027;
        walk("R7_nx_fetch_fault", 32'h0040_3000, 0, 0, 0, 1, 0, 0, 1);
        walk("R7_nx_off_reserved", 32'h0040_3000, 0, 0, 0, 1, 0, 0, 0);
        mem[52'h20018] = 64'h0ABCD067;
        walk("R7_nx_fetch_ok", 32'h0040_3000, 0, 0, 0, 1, 0, 0, 1);
        // R11: read-modify-write sets Dirty
        mem[52'h20018] = 64'h0ABCD027;
        walk("R11_rmw_dirty", 32'h0040_3000, 0, 1, 0, 0, 0, 0, 0);

        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule